// File: doc/BRIEF.md
# Chip-Interleaved Column Parity Generator

This block produces and checks a small set of parity bits that protect a cache line held in off-chip DRAM. The line is split into read-blocks, and each read-block is a row of equal-width DRAM chips laid side by side. A parity bit does not cover a run of neighbouring data bits. Instead it takes the same bit lane from every chip in the read-block. If one whole chip returns garbage, the syndrome for its read-block is therefore exactly that chip's flip pattern. A correction search can use it to narrow the candidates it has to try.

When a line is written back, the block is given the line and returns the parity bits to be stored next to it. Ordinary reads do not use the block. It is consulted only after an integrity check has failed: the line as read and the stored parity go in, and the per-read-block syndrome comes out. Both operations are single-beat and pipelined. Results are registered and appear one clock after the input beat.

Top module: `colpar_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid is 0 and out_parity, out_syndrome, out_op and out_err are all 0.
- R2: With chip width W and C chips per read-block, chip c of read-block k occupies in_data bits [k*W*C + c*W + W-1 : k*W*C + c*W]. Parity lane j of read-block k is the XOR of in_data bit k*W*C + c*W + j over all chips c.
- R3: The parity of read-block k is placed in out_parity bits [k*W + W-1 : k*W], so the default line of two 256-bit read-blocks made of 64 four-bit chips yields 8 parity bits.
- R4: In generate mode (in_op = 0) the result has out_syndrome equal to 0 and out_err equal to 0.
- R5: In check mode (in_op = 1) out_syndrome equals in_stored XOR the recomputed parity, bit for bit in the R3 layout.
- R6: out_err is 1 exactly when a valid result carries a nonzero out_syndrome.
- R7: Every beat with in_valid = 1 yields out_valid = 1 on the next clock edge, with out_op equal to that beat's in_op. A cycle with in_valid = 0 yields out_valid = 0 on the next edge, so back-to-back beats give back-to-back results.
- R8: A cycle with in_valid = 0 has no effect on out_parity, out_syndrome, out_op or out_err, whatever in_data, in_stored and in_op hold.
- R9: In check mode, XORing a pattern p into any single chip of read-block k, with the stored parity taken from the original line, gives out_syndrome = p placed in bits [k*W + W-1 : k*W] and zero elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_op | input | 1 | 0 = generate parity, 1 = check against stored parity |
| in_data | input | LINE_W (512) | Cache line, read-blocks packed from bit 0 upward |
| in_stored | input | PAR_W (8) | Previously stored parity, used in check mode |
| out_valid | output | 1 | Result present, one cycle after in_valid |
| out_op | output | 1 | Operation of the reported result |
| out_parity | output | PAR_W (8) | Recomputed column parity, W bits per read-block |
| out_syndrome | output | PAR_W (8) | Stored XOR recomputed parity in check mode, zero otherwise |
| out_err | output | 1 | Syndrome is nonzero |

## Verification
The bound checker watches the timing and framing on every cycle. It checks that each beat yields exactly one result on the next edge and that the operation is echoed. It checks that generate-mode results never carry a syndrome, that the error flag always agrees with the syndrome, and that idle cycles leave every result register untouched. Only the bench's scenarios can show the actual parity values: the bit-lane mapping across chips, the placement of each read-block's bits, and the claim that corrupting a single chip makes its flip pattern appear as the syndrome. The bench checks these against parity recomputed by bit counting. It does this exhaustively on a 16-bit configuration that uses the linear fold, and by directed and random lines on the default tree-fold configuration.

// File: rtl/colpar_pkg.sv
package colpar_pkg;

   typedef enum logic {
      CP_GEN = 1'b0,
      CP_CHK = 1'b1
   } cp_op_e;

endpackage

// File: rtl/colpar_fold.sv
module colpar_fold #(
   parameter int LANE_W    = 4,
   parameter int N_CHIPS   = 64,
   parameter bit FOLD_TREE = 1'b1
) (
   input  logic [LANE_W*N_CHIPS-1:0] blk,
   output logic [LANE_W-1:0]         par
);

   generate
      if (FOLD_TREE) begin : g_tree
         for (genvar j = 0; j < LANE_W; j++) begin : g_lane
            logic [N_CHIPS-1:0] col;
            for (genvar c = 0; c < N_CHIPS; c++) begin : g_chip
               assign col[c] = blk[c*LANE_W + j];
            end
            assign par[j] = ^col;
         end
      end else begin : g_linear
         always_comb begin
            par = '0;
            for (int c = 0; c < N_CHIPS; c++) begin
               par = par ^ blk[c*LANE_W +: LANE_W];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/colpar_stage.sv
module colpar_stage
   import colpar_pkg::*;
#(
   parameter int PAR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld,
   input  logic             op,
   input  logic [PAR_W-1:0] par,
   input  logic [PAR_W-1:0] stored,
   output logic             q_valid,
   output logic             q_op,
   output logic [PAR_W-1:0] q_par,
   output logic [PAR_W-1:0] q_syn,
   output logic             q_err
);

   logic             is_chk;
   logic [PAR_W-1:0] diff;

   assign is_chk = (cp_op_e'(op) == CP_CHK);
   assign diff   = stored ^ par;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_op    <= 1'b0;
         q_par   <= '0;
         q_syn   <= '0;
         q_err   <= 1'b0;
      end else begin
         q_valid <= ld;
         if (ld) begin
            q_op  <= op;
            q_par <= par;
            q_syn <= is_chk ? diff : '0;
            q_err <= is_chk && (stored != par);
         end
      end
   end

endmodule

// File: rtl/colpar_gen.sv
module colpar_gen #(
   parameter int LANE_W    = 4,
   parameter int N_CHIPS   = 64,
   parameter int N_RBLK    = 2,
   parameter bit FOLD_TREE = 1'b1,
   localparam int RBLK_W   = LANE_W * N_CHIPS,
   localparam int LINE_W   = RBLK_W * N_RBLK,
   localparam int PAR_W    = LANE_W * N_RBLK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_op,
   input  logic [LINE_W-1:0] in_data,
   input  logic [PAR_W-1:0]  in_stored,
   output logic              out_valid,
   output logic              out_op,
   output logic [PAR_W-1:0]  out_parity,
   output logic [PAR_W-1:0]  out_syndrome,
   output logic              out_err
);

   generate
      if (LANE_W < 1) begin : g_bad_lane
         $error("colpar_gen: LANE_W must be at least 1");
      end
      if (N_CHIPS < 2) begin : g_bad_chips
         $error("colpar_gen: N_CHIPS must be at least 2");
      end
      if (N_RBLK < 1) begin : g_bad_rblk
         $error("colpar_gen: N_RBLK must be at least 1");
      end
   endgenerate

   logic [PAR_W-1:0] par_comb;

   for (genvar k = 0; k < N_RBLK; k++) begin : g_rblk
      colpar_fold #(
         .LANE_W    (LANE_W),
         .N_CHIPS   (N_CHIPS),
         .FOLD_TREE (FOLD_TREE)
      ) u_fold (
         .blk (in_data[k*RBLK_W +: RBLK_W]),
         .par (par_comb[k*LANE_W +: LANE_W])
      );
   end

   colpar_stage #(
      .PAR_W (PAR_W)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (in_valid),
      .op      (in_op),
      .par     (par_comb),
      .stored  (in_stored),
      .q_valid (out_valid),
      .q_op    (out_op),
      .q_par   (out_parity),
      .q_syn   (out_syndrome),
      .q_err   (out_err)
   );

endmodule

// File: rtl/colpar_chk.sv
module colpar_chk #(
   parameter int PAR_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_op,
   input logic             out_valid,
   input logic             out_op,
   input logic [PAR_W-1:0] out_parity,
   input logic [PAR_W-1:0] out_syndrome,
   input logic             out_err
);

   a_r7_beat_to_result: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r7_idle_no_result: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   a_r7_op_echo: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_op == $past(in_op)));

   a_r4_gen_clean: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_op) |-> ((out_syndrome == '0) && !out_err));

   a_r6_err_matches_syn: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_err == (out_syndrome != '0)));

   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_parity) && $stable(out_syndrome)
                     && $stable(out_op) && $stable(out_err)));

endmodule

bind colpar_gen colpar_chk #(.PAR_W(PAR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .in_op        (in_op),
   .out_valid    (out_valid),
   .out_op       (out_op),
   .out_parity   (out_parity),
   .out_syndrome (out_syndrome),
   .out_err      (out_err)
);

// File: tb/colpar_gen_bench.sv
`timescale 1ns/1ps
module colpar_gen_bench;

   localparam int LW  = 4;
   localparam int NC  = 64;
   localparam int RB  = 2;
   localparam int DW  = LW*NC*RB;
   localparam int PW  = LW*RB;
   localparam int SLW = 2;
   localparam int SNC = 4;
   localparam int SRB = 2;
   localparam int SDW = SLW*SNC*SRB;
   localparam int SPW = SLW*SRB;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;
   logic rst_n;

   logic          in_valid, in_op;
   logic [DW-1:0] in_data;
   logic [PW-1:0] in_stored;
   logic          out_valid, out_op, out_err;
   logic [PW-1:0] out_parity, out_syndrome;

   logic           s_valid, s_op;
   logic [SDW-1:0] s_data;
   logic [SPW-1:0] s_stored;
   logic           s_ovalid, s_oop, s_oerr;
   logic [SPW-1:0] s_opar, s_osyn;

   colpar_gen #(.LANE_W(LW), .N_CHIPS(NC), .N_RBLK(RB), .FOLD_TREE(1'b1)) u_colpar_gen (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_data(in_data), .in_stored(in_stored), .out_valid(out_valid),
      .out_op(out_op), .out_parity(out_parity), .out_syndrome(out_syndrome),
      .out_err(out_err));

   colpar_gen #(.LANE_W(SLW), .N_CHIPS(SNC), .N_RBLK(SRB), .FOLD_TREE(1'b0)) u_colpar_gen_small (
      .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_op(s_op),
      .in_data(s_data), .in_stored(s_stored), .out_valid(s_ovalid),
      .out_op(s_oop), .out_parity(s_opar), .out_syndrome(s_osyn),
      .out_err(s_oerr));

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   function automatic logic [PW-1:0] ref_par(input logic [DW-1:0] d);
      logic [PW-1:0] r;
      r = '0;
      for (int k = 0; k < RB; k++) begin
         for (int j = 0; j < LW; j++) begin
            logic [DW-1:0] m;
            m = '0;
            for (int c = 0; c < NC; c++) m[k*LW*NC + c*LW + j] = 1'b1;
            r[k*LW + j] = ($countones(d & m) % 2) == 1;
         end
      end
      return r;
   endfunction

   function automatic logic [SPW-1:0] ref_par_s(input logic [SDW-1:0] d);
      logic [SPW-1:0] r;
      r = '0;
      for (int k = 0; k < SRB; k++) begin
         for (int j = 0; j < SLW; j++) begin
            logic [SDW-1:0] m;
            m = '0;
            for (int c = 0; c < SNC; c++) m[k*SLW*SNC + c*SLW + j] = 1'b1;
            r[k*SLW + j] = ($countones(d & m) % 2) == 1;
         end
      end
      return r;
   endfunction

   function automatic logic [DW-1:0] rand_line();
      logic [DW-1:0] v;
      for (int w = 0; w < DW/32; w++) v[w*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One beat on the large instance; called at a negedge, returns at the next negedge.
   task automatic beat(input logic [DW-1:0] d, input logic [PW-1:0] st, input logic op,
                       input logic [PW-1:0] exp_syn);
      logic [PW-1:0] ep;
      ep = ref_par(d);
      in_valid = 1'b1; in_op = op; in_data = d; in_stored = st;
      @(negedge clk);
      check("R7 out_valid", DW'(out_valid), DW'(1));
      check("R7 out_op", DW'(out_op), DW'(op));
      check("R2/R3 parity", DW'(out_parity), DW'(ep));
      check(op ? "R5 syndrome" : "R4 syndrome", DW'(out_syndrome), DW'(exp_syn));
      check("R6 err", DW'(out_err), DW'(exp_syn != '0));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] d, d2;
      logic [PW-1:0] p0, lastp, lasts;
      rst_n = 1'b0;
      in_valid = 1'b0; in_op = 1'b0; in_data = '0; in_stored = '0;
      s_valid = 1'b0; s_op = 1'b0; s_data = '0; s_stored = '0;
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1 out_valid", DW'(out_valid), DW'(0));
      check("R1 out_parity", DW'(out_parity), DW'(0));
      check("R1 out_syndrome", DW'(out_syndrome), DW'(0));
      check("R1 out_err", DW'(out_err), DW'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", DW'({out_valid, out_op, out_err, out_parity, out_syndrome}), DW'(0));

      // R2/R3: directed lines
      beat('0, '0, 1'b0, '0);
      beat('1, '0, 1'b0, '0);                        // 64 chips: even count per lane
      d = '0; d[0] = 1'b1;                           // chip 0 lane 0 of block 0
      beat(d, '0, 1'b0, '0);
      check("R3 block0 lane0", DW'(out_parity), DW'(8'h01));
      d = '0; d[256 + 61*4 + 2] = 1'b1;              // block 1, chip 61, lane 2
      beat(d, '0, 1'b0, '0);
      check("R3 block1 lane2", DW'(out_parity), DW'(8'h40));
      d = '0; d[3:0] = 4'hF; d[7:4] = 4'h5;          // two chips fold together
      beat(d, '0, 1'b0, '0);
      check("R2 fold two chips", DW'(out_parity), DW'(8'h0A));
      for (int i = 0; i < 40; i++) beat(rand_line(), PW'($urandom), 1'b0, '0);

      // R5: check mode, matching and arbitrary stored values
      for (int i = 0; i < 40; i++) begin
         logic [PW-1:0] st;
         d = rand_line();
         st = (i % 2 == 0) ? ref_par(d) : PW'($urandom);
         beat(d, st, 1'b1, st ^ ref_par(d));
      end

      // R9: single-chip corruption maps to that block's syndrome
      for (int k = 0; k < RB; k++) begin
         for (int c = 0; c < NC; c += 9) begin
            logic [LW-1:0] pat;
            d = rand_line();
            p0 = ref_par(d);
            pat = LW'((c % 15) + 1);
            d2 = d;
            d2[k*LW*NC + c*LW +: LW] = d2[k*LW*NC + c*LW +: LW] ^ pat;
            beat(d2, p0, 1'b1, PW'(pat) << (k*LW));
            check("R9 chip pattern", DW'(out_syndrome), DW'(PW'(pat) << (k*LW)));
         end
      end

      // R8 / R7: idle cycles change nothing and give no result
      d = rand_line();
      beat(d, ~ref_par(d), 1'b1, ~'0);
      lastp = out_parity; lasts = out_syndrome;
      for (int i = 0; i < 4; i++) begin
         in_valid = 1'b0; in_op = i[0]; in_data = rand_line(); in_stored = PW'($urandom);
         @(negedge clk);
         check("R7 idle no valid", DW'(out_valid), DW'(0));
         check("R8 parity held", DW'(out_parity), DW'(lastp));
         check("R8 syndrome held", DW'(out_syndrome), DW'(lasts));
         check("R8 op/err held", DW'({out_op, out_err}), DW'(2'b11));
      end

      // Exhaustive sweep on the small configuration (linear fold)
      for (int i = 0; i < (1 << SDW); i++) begin
         logic [SDW-1:0] sd;
         sd = SDW'(i);
         s_valid = 1'b1; s_op = 1'b0; s_data = sd; s_stored = SPW'(i * 7);
         @(negedge clk);
         check("R2 small gen parity", DW'({s_ovalid, s_oerr, s_osyn, s_opar}),
               DW'({1'b1, 1'b0, SPW'(0), ref_par_s(sd)}));
      end
      for (int i = 0; i < (1 << (SDW - 1)); i++) begin
         logic [SDW-1:0] sd;
         logic [SPW-1:0] ss, es;
         sd = SDW'(i * 40503);
         ss = SPW'(i);
         es = ss ^ ref_par_s(sd);
         s_valid = 1'b1; s_op = 1'b1; s_data = sd; s_stored = ss;
         @(negedge clk);
         check("R5 small check syndrome", DW'({s_ovalid, s_oop, s_oerr, s_osyn}),
               DW'({1'b1, 1'b1, es != '0, es}));
      end
      s_valid = 1'b0;
      @(negedge clk);
      check("R7 small idle", DW'(s_ovalid), DW'(0));

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule